// File: doc/BRIEF.md
# Pulse Width and Period Capture Timer

This block measures a digital input in units of the system clock. After it is started, it waits for a rising edge of the input. It then records how many cycles the input stays high (the width) and how many cycles pass from that rising edge to the next one (the period). The counter then restarts for the next cycle of the signal, so the two capture registers always hold the latest measurement.

The measured input comes from one of two lines: the timer's own pin or a serial receive line. Software uses the receive line to time the bits of an incoming character and work out the baud rate. A control bit picks whether the interrupt flag rises when a width is captured or when a period is captured. When the free-running counter reaches its all-ones value, the timer stops itself and raises a sticky overflow flag. Both status flags stay set until software writes ones to them.

Software reaches the block through a flat register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `pwcap_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The register offsets are: 0 control, 1 status, 2 width, 3 period, 4 live count.
- R2: Once running, the block arms on the first rising edge of the synchronized input. The width register then receives the number of clock cycles the input stayed high.
- R3: The next rising edge loads the period register with the number of cycles since the previous rising edge, and the count restarts at 1.
- R4: Control bit 1 chooses when status bit 0 (interrupt flag) is set. When it is 1, the flag is set on a period capture. When it is 0, the flag is set on a width capture.
- R5: On the first rising edge after the timer is started, the period register is cleared. It therefore reads 0 at the first width capture.
- R6: When the live count reaches all ones, control bit 0 (run) clears, the count returns to 0 and status bit 1 (overflow) is set. Status bit 0 is also set, but only if control bit 3 (interrupt enable) is 1.
- R7: The status flags are sticky. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If a flag's set event and a write-one clear of that flag land on the same clock edge, the flag ends up set.
- R9: Control bit 2 selects the measured input: 1 selects `rx_line` and 0 selects `tmr_pin`. Activity on the line that is not selected has no effect on the results.
- R10: `irq` is high exactly when status bit 0 and control bit 3 are both 1.
- R11: Clearing control bit 0 forces the live count to 0. It leaves the width register, the period register and both status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_pin | input | 1 | Dedicated timer input, asynchronous |
| rx_line | input | 1 | Serial receive line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench drives pulses of known length through the synchronizer and checks each capture against the cycle counts it scheduled. If the design counted from the raw edge or latched one cycle late, the results would be off by one. The first width capture after a start must report a zero period; a design that kept an old period would fail this check. A write-one clear is placed on exactly the edge where a width is captured, so a design where the clear wins would lose the interrupt. The bench holds the input high until the narrowed counter saturates: the timer must stop, set the overflow flag, and gate the interrupt flag on the enable bit. A design that wrapped around, or kept running, would be caught.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

  localparam int B_IRQ = 0;
  localparam int B_OVF = 1;
  localparam int CTRL_W = 4;

  // bit 0 run, bit 1 period interrupt, bit 2 receive select, bit 3 irq enable
  typedef struct packed {
    logic irq_en;
    logic rx_sel;
    logic period_sel;
    logic run;
  } ctrl_t;

  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_ARM  = 2'd1,
    PW_HIGH = 2'd2,
    PW_LOW  = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pwcap_rst_sync.sv
module pwcap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwcap_insync.sv
module pwcap_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;
  logic              level;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b0;
        else        stg_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign level = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/pwcap_counter.sv
module pwcap_counter
  import pwcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rise,
  input  logic             fall,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] width,
  output logic [CNT_W-1:0] period,
  output logic             ev_start,
  output logic             ev_width,
  output logic             ev_period,
  output logic             ev_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  pw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] width_q, width_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             width_en, period_en;
  logic             saturated;

  assign saturated = (cnt_q == CNT_MAX);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    width_d   = width_q;
    period_d  = period_q;
    width_en  = 1'b0;
    period_en = 1'b0;
    ev_start  = 1'b0;
    ev_width  = 1'b0;
    ev_period = 1'b0;
    ev_ovf    = 1'b0;
    if (!run) begin
      state_d = PW_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PW_IDLE: begin
          state_d = PW_ARM;
          cnt_d   = '0;
        end
        PW_ARM: begin
          if (rise) begin
            state_d   = PW_HIGH;
            cnt_d     = CNT_ONE;
            period_d  = '0;
            period_en = 1'b1;
            ev_start  = 1'b1;
          end
        end
        PW_HIGH: begin
          if (saturated) begin
            state_d = PW_IDLE;
            cnt_d   = '0;
            ev_ovf  = 1'b1;
          end else if (fall) begin
            state_d  = PW_LOW;
            width_d  = cnt_q;
            width_en = 1'b1;
            ev_width = 1'b1;
            cnt_d    = cnt_q + CNT_ONE;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        PW_LOW: begin
          if (saturated) begin
            state_d = PW_IDLE;
            cnt_d   = '0;
            ev_ovf  = 1'b1;
          end else if (rise) begin
            state_d   = PW_HIGH;
            period_d  = cnt_q;
            period_en = 1'b1;
            ev_period = 1'b1;
            cnt_d     = CNT_ONE;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        default: begin
          state_d = PW_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        width_q <= '0;
    else if (width_en) width_q <= width_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= '0;
    else if (period_en) period_q <= period_d;
  end

  assign count  = cnt_q;
  assign width  = width_q;
  assign period = period_q;
endmodule

// File: rtl/pwcap_regs.sv
module pwcap_regs
  import pwcap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_width,
  input  logic              ev_period,
  input  logic              ev_ovf,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  width,
  input  logic [CNT_W-1:0]  period,
  output ctrl_t             ctrl,
  output logic              irq_flag,
  output logic              ovf_flag,
  output logic              clr_irq,
  output logic              clr_ovf,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t ctrl_q, ctrl_d;
  logic  irq_q, irq_d;
  logic  ovf_q, ovf_d;
  logic  ctrl_wr, stat_wr;
  logic  set_irq;
  logic  unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign clr_irq = stat_wr & wdata[B_IRQ];
  assign clr_ovf = stat_wr & wdata[B_OVF];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (ev_ovf)  ctrl_d.run = 1'b0;
  end

  always_comb begin
    set_irq = (ctrl_q.period_sel ? ev_period : ev_width) | (ev_ovf & ctrl_q.irq_en);
    irq_d   = set_irq | (irq_q & ~clr_irq);
    ovf_d   = ev_ovf | (ovf_q & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:   rdata = DATA_W'(ctrl_q);
      A_STAT:   rdata = DATA_W'({ovf_q, irq_q});
      A_WIDTH:  rdata = DATA_W'(width);
      A_PERIOD: rdata = DATA_W'(period);
      A_COUNT:  rdata = DATA_W'(count);
      default:  rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign irq_flag = irq_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_pin,
  input  logic              rx_line,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             rst_ni;
  ctrl_t            ctrl;
  logic             run, period_sel, irq_en;
  logic             sel_in, rise, fall;
  logic [CNT_W-1:0] count, width_q, period_q;
  logic             ev_start, ev_width, ev_period, ev_ovf;
  logic             irq_flag, ovf_flag, clr_irq, clr_ovf;

  assign run        = ctrl.run;
  assign period_sel = ctrl.period_sel;
  assign irq_en     = ctrl.irq_en;
  assign sel_in     = ctrl.rx_sel ? rx_line : tmr_pin;

  pwcap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  pwcap_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .din(sel_in), .rise(rise), .fall(fall)
  );

  pwcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .run(run), .rise(rise), .fall(fall),
    .count(count), .width(width_q), .period(period_q),
    .ev_start(ev_start), .ev_width(ev_width), .ev_period(ev_period), .ev_ovf(ev_ovf)
  );

  pwcap_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ev_width(ev_width), .ev_period(ev_period), .ev_ovf(ev_ovf),
    .count(count), .width(width_q), .period(period_q),
    .ctrl(ctrl), .irq_flag(irq_flag), .ovf_flag(ovf_flag),
    .clr_irq(clr_irq), .clr_ovf(clr_ovf), .rdata(reg_rdata)
  );

  assign irq = irq_flag & irq_en;
endmodule

// File: rtl/pwcap_timer_chk.sv
module pwcap_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             period_sel,
  input logic             irq_en,
  input logic             irq,
  input logic             irq_flag,
  input logic             ovf_flag,
  input logic             clr_irq,
  input logic             clr_ovf,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] width_q,
  input logic [CNT_W-1:0] period_q,
  input logic             ev_start,
  input logic             ev_width,
  input logic             ev_period,
  input logic             ev_ovf
);
  // R2
  width_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_width |=> (width_q == $past(count)));

  // R3
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_period |=> ((period_q == $past(count)) && (count == CNT_W'(1))));

  // R4
  irq_on_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_period && period_sel) |=> irq_flag);

  // R4
  irq_on_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_width && !period_sel) |=> irq_flag);

  // R5
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (period_q == '0));

  // R6
  ovf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> (!run && ovf_flag && (count == '0)));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_irq) |=> irq_flag);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  // R8
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && clr_ovf) |=> ovf_flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_en);

  // R11
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  // R11
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> ($stable(width_q) && $stable(period_q)));
endmodule

bind pwcap_timer pwcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_ni), .run(run), .period_sel(period_sel), .irq_en(irq_en),
  .irq(irq), .irq_flag(irq_flag), .ovf_flag(ovf_flag), .clr_irq(clr_irq),
  .clr_ovf(clr_ovf), .count(count), .width_q(width_q), .period_q(period_q),
  .ev_start(ev_start), .ev_width(ev_width), .ev_period(ev_period), .ev_ovf(ev_ovf)
);

// File: tb/pwcap_timer_test.sv
module pwcap_timer_test;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 12;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              tmr_pin, rx_line;
  logic              reg_wr;
  logic [2:0]        reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int  errs, checks, ncyc;
  bit  use_rx, noise, done;

  pwcap_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_pin(tmr_pin), .rx_line(rx_line),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ctrl_word(bit run, bit psel, bit rxs, bit ien);
    return (int'(ien) << 3) | (int'(rxs) << 2) | (int'(psel) << 1) | int'(run);
  endfunction

  function automatic int flag_after_width(bit psel);
    return psel ? 0 : 1;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ncyc++;
    if (noise) begin
      if (use_rx) tmr_pin = 1'($urandom);
      else        rx_line = 1'($urandom);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [2:0] a, int d);
    tick();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DATA_W'(d);
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output longint d);
    tick();
    reg_addr = a;
    #1;
    d = longint'(reg_rdata);
  endtask

  task automatic set_in(bit v);
    if (use_rx) rx_line = v;
    else        tmr_pin = v;
  endtask

  task automatic restart(bit psel, bit rxs, bit ien);
    wr(3'd0, 0);
    tmr_pin = 1'b0; rx_line = 1'b0;
    use_rx = rxs;
    wait_n(4);
    wr(3'd1, 3);
    wr(3'd0, ctrl_word(1, psel, rxs, ien));
    wait_n(4);
  endtask

  longint v;
  int     t0, t1, t2;

  initial begin
    errs = 0; checks = 0; ncyc = 0; done = 0;
    use_rx = 0; noise = 0;
    rst_n = 1'b0; tmr_pin = 1'b0; rx_line = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    void'($urandom(32'd4711));
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg reset", v, 0);
    end
    #1 chk("R1 irq reset", longint'(irq), 0);

    // R2 R5 R4: width first, period reads 0, flag on width capture
    restart(0, 0, 1);
    set_in(1); t0 = ncyc;
    wait_n(9);
    set_in(0); t1 = ncyc;
    wait_n(4);
    rd(3'd2, v); chk("R2 width", v, t1 - t0);
    rd(3'd3, v); chk("R5 period zero before first period", v, 0);
    rd(3'd1, v); chk("R4 flag on width capture", v & 1, 1);
    #1 chk("R10 irq with enable", longint'(irq), 1);
    // R7 write zero keeps, write one clears
    wr(3'd1, 0);
    rd(3'd1, v); chk("R7 zero write keeps flag", v & 1, 1);
    wr(3'd1, 1);
    rd(3'd1, v); chk("R7 one write clears flag", v & 1, 0);
    wait_n(2);
    set_in(1); t2 = ncyc;
    wait_n(5);
    rd(3'd3, v); chk("R3 period", v, t2 - t0);
    rd(3'd1, v); chk("R4 no flag on period when width mode", v & 1, 0);
    rd(3'd4, v); chk("R3 count restarted", longint'(v < 10), 1);

    // R4 period mode
    restart(1, 0, 1);
    set_in(1); t0 = ncyc;
    wait_n(6);
    set_in(0); t1 = ncyc;
    wait_n(4);
    rd(3'd1, v); chk("R4 no flag on width when period mode", v & 1, 0);
    rd(3'd2, v); chk("R2 width period mode", v, t1 - t0);
    wait_n(3);
    set_in(1); t2 = ncyc;
    wait_n(5);
    rd(3'd1, v); chk("R4 flag on period capture", v & 1, 1);
    rd(3'd3, v); chk("R3 period period mode", v, t2 - t0);

    // R11 disable mid-measure
    rd(3'd4, v); chk("R11 count running", longint'(v != 0), 1);
    wr(3'd0, ctrl_word(0, 1, 0, 1));
    wait_n(2);
    rd(3'd4, v); chk("R11 count cleared on disable", v, 0);
    rd(3'd2, v); chk("R11 width kept", v, t1 - t0);
    rd(3'd3, v); chk("R11 period kept", v, t2 - t0);
    rd(3'd1, v); chk("R11 flag kept", v & 1, 1);

    // R10 gating
    restart(0, 0, 0);
    set_in(1); wait_n(4); set_in(0); wait_n(5);
    rd(3'd1, v); chk("R10 flag set", v & 1, 1);
    #1 chk("R10 irq gated off", longint'(irq), 0);
    wr(3'd0, ctrl_word(1, 0, 0, 1));
    #1 chk("R10 irq after enable", longint'(irq), 1);

    // R8 clear lands on capture edge
    restart(0, 0, 1);
    set_in(1); wait_n(5);
    tick(); set_in(0);
    tick();
    wr(3'd1, 1);
    rd(3'd1, v); chk("R8 set wins over clear", v & 1, 1);

    // R9 receive line selected, timer pin noisy
    restart(0, 1, 1);
    noise = 1;
    set_in(1); t0 = ncyc;
    wait_n(11);
    set_in(0); t1 = ncyc;
    wait_n(4);
    rd(3'd2, v); chk("R9 rx width with pin noise", v, t1 - t0);
    noise = 0;

    // random mix
    for (int it = 0; it < 16; it++) begin
      int h, l;
      bit ps, rs;
      h  = 1 + int'($urandom % 30);
      l  = 8 + int'($urandom % 25);
      ps = 1'($urandom);
      rs = 1'($urandom);
      restart(ps, rs, 1);
      noise = 1;
      set_in(1); t0 = ncyc;
      wait_n(h);
      set_in(0); t1 = ncyc;
      wait_n(4);
      rd(3'd1, v); chk("R4 random flag after width", v & 1, flag_after_width(ps));
      rd(3'd2, v); chk("R9 R2 random width", v, t1 - t0);
      rd(3'd3, v); chk("R5 random zero period", v, 0);
      wait_n(l - 6);
      set_in(1); t2 = ncyc;
      wait_n(5);
      rd(3'd3, v); chk("R3 random period", v, t2 - t0);
      rd(3'd1, v); chk("R4 random flag after period", v & 1, 1);
      noise = 0;
    end

    // R6 overflow with irq enable
    restart(0, 0, 1);
    set_in(1);
    wait_n(MAXC + 40);
    rd(3'd1, v); chk("R6 overflow and flag", v, 3);
    rd(3'd0, v); chk("R6 run cleared", v & 1, 0);
    rd(3'd4, v); chk("R6 count zero", v, 0);
    #1 chk("R6 irq raised", longint'(irq), 1);
    wr(3'd1, 2);
    rd(3'd1, v); chk("R7 overflow cleared alone", v, 1);

    // R6 overflow without irq enable
    restart(0, 0, 0);
    set_in(1);
    wait_n(MAXC + 40);
    rd(3'd1, v); chk("R6 overflow without flag", v, 2);
    rd(3'd0, v); chk("R6 run cleared again", v & 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule